// File: doc/BRIEF.md
# DMA Controller Register File

This block holds the host-visible registers of a four-channel DMA controller. The host reaches it over an 8-bit port bus that is selected by a 5-bit port index. Each channel keeps a 16-bit starting address and a 16-bit starting count. Each of those values also has a working copy. A channel further holds a 6-bit mode field and an 8-bit page value. The controller as a whole keeps a command byte, a four-bit mask set, software request bits, latched terminal-count flags, and one byte pointer. The byte pointer selects which half of a 16-bit value the next access touches.

The transfer sequencer and the arbiter sit next to this block and drive it through two inputs. One pulses terminal-count events in. The other presents hardware request lines. The block sends all of its stored state back to them on flat output buses.

Port index map: 0..7 select the channel registers. For these, index bits 2:1 pick the channel and bit 0 picks address (0) or count (1). The other ports are:
- 8: read status, write command
- 9: software request
- 10: single mask
- 11: mode
- 12: byte pointer clear
- 13: master clear
- 14: unmask all
- 15: load all masks
- 16..19: page of channels 0..3

Top module: `dma_regfile`

## Requirements
- R1: After reset, maskOut is 4'hF, statusOut is 0, cmdOut is 0, and every mode, page, address and count field is 0. The byte pointer is 0, so the first byte access touches the low half.
- R2: A write to an address or count port loads the same byte into both the starting copy and the working copy of that value. The byte goes to bits 7:0 when the pointer is 0 and to bits 15:8 when it is 1. The other half keeps its value, and the pointer toggles.
- R3: A read of an address or count port returns the working copy. It returns bits 7:0 when the pointer is 0 and bits 15:8 when it is 1, then toggles the pointer.
- R4: Status bits 7..4 are the OR of the software request bits and hwReq for channels 3..0. Bits 3..0 latch tcSet pulses for channels 3..0. A read of port 8 returns status, then clears bits 3..0. A tcSet pulse in the same cycle as that read still sets its bit.
- R5: A write to port 10 sets the mask of channel wrData[1:0] to wrData[2].
- R6: A write to port 11 stores wrData[7:2] as the mode field of channel wrData[1:0]. Within that field: bits 7:6 are the mode (0 demand, 1 single, 2 block, 3 cascade), bit 5 selects decrement, bit 4 selects auto-init, and bits 3:2 are the transfer type (0 verify, 1 to memory, 2 from memory, 3 undefined). Slice c of modeFlat is bits [6c+5:6c].
- R7: A write of any value to port 13 does the following. It sets all masks, clears the command byte, the software requests and the terminal-count flags, and returns the pointer to 0.
- R8: A write to port 14 clears all masks. A write to port 15 loads mask bits 3..0 from wrData[3:0].
- R9: A write to port 9 sets the software request bit of channel wrData[1:0] when wrData[2] is 1, and clears it when wrData[2] is 0.
- R10: A write of any value to port 12 returns the pointer to 0.
- R11: Ports 16..19 write and read the page of channels 0..3, which appears on pageFlat bits [8c+7:8c].
- R12: A write to port 8 stores the command byte on cmdOut. A read of port 13 or of any port above 19 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Port write strobe; takes priority over rdEn |
| rdEn | input | 1 | Port read strobe; side effects at the clock edge |
| portIdx | input | 5 | Port index |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from current state |
| tcSet | input | 4 | Terminal-count pulses from the sequencer |
| hwReq | input | 4 | Hardware request lines |
| maskOut | output | 4 | Channel mask bits |
| cmdOut | output | 8 | Command byte |
| statusOut | output | 8 | Live status value |
| modeFlat | output | 24 | Mode fields, 6 bits per channel |
| pageFlat | output | 32 | Page values, 8 bits per channel |
| baseAddrFlat | output | 64 | Starting addresses, 16 bits per channel |
| curAddrFlat | output | 64 | Working addresses |
| baseCntFlat | output | 64 | Starting counts |
| curCntFlat | output | 64 | Working counts |

## Verification
The bound checker watches every cycle for several properties:
- the mask effects of the single-mask, unmask-all, load-all and master-clear commands;
- the clearing of terminal-count flags after a status read;
- the holding of terminal-count pulses;
- the equality of starting and working address copies after an address write.

Some behaviours can only be shown by the directed scenarios, because the pointer state is internal and visible only through data order. These are:
- the byte-lane order and pointer toggling on reads and writes;
- the effect of a pointer clear between bytes;
- the encoding of the status byte;
- the zero returned by unimplemented ports.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;

  localparam int PORT_W = 5;

  localparam logic [PORT_W-1:0] P_STATCMD = 5'd8;
  localparam logic [PORT_W-1:0] P_SWREQ   = 5'd9;
  localparam logic [PORT_W-1:0] P_ONEMASK = 5'd10;
  localparam logic [PORT_W-1:0] P_MODE    = 5'd11;
  localparam logic [PORT_W-1:0] P_PTRCLR  = 5'd12;
  localparam logic [PORT_W-1:0] P_MCLR    = 5'd13;
  localparam logic [PORT_W-1:0] P_UNMASK  = 5'd14;
  localparam logic [PORT_W-1:0] P_ALLMASK = 5'd15;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_ADDR,
    RD_CNT,
    RD_STATUS,
    RD_PAGE
  } rdKind_t;

  typedef struct packed {
    logic [1:0] chan;
    logic       hiByte;
    logic       wrAddr;
    logic       wrCnt;
    logic       wrCmd;
    logic       wrReq;
    logic       wrOneMask;
    logic       wrMode;
    logic       masterClr;
    logic       clrMasks;
    logic       wrAllMasks;
    logic       wrPage;
    logic       rdStatus;
    rdKind_t    rdKind;
  } strobe_t;

endpackage

// File: rtl/dma_regfile_ctrl.sv
module dma_regfile_ctrl
  import dma_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [PORT_W-1:0] portIdx,
  output strobe_t           stb
);

  logic bytePtr;
  logic isChanPort;
  logic isPagePort;

  assign isChanPort = (portIdx[4:3] == 2'b00);
  assign isPagePort = (portIdx[4:2] == 3'b100);

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_ZERO;
    stb.hiByte = bytePtr;
    stb.chan   = isChanPort ? portIdx[2:1] : portIdx[1:0];
    if (wrEn) begin
      if (isChanPort) begin
        stb.wrAddr = !portIdx[0];
        stb.wrCnt  = portIdx[0];
      end else if (isPagePort) begin
        stb.wrPage = 1'b1;
      end else begin
        case (portIdx)
          P_STATCMD: stb.wrCmd      = 1'b1;
          P_SWREQ:   stb.wrReq      = 1'b1;
          P_ONEMASK: stb.wrOneMask  = 1'b1;
          P_MODE:    stb.wrMode     = 1'b1;
          P_MCLR:    stb.masterClr  = 1'b1;
          P_UNMASK:  stb.clrMasks   = 1'b1;
          P_ALLMASK: stb.wrAllMasks = 1'b1;
          default:   ;
        endcase
      end
    end else if (rdEn) begin
      if (isChanPort) begin
        stb.rdKind = portIdx[0] ? RD_CNT : RD_ADDR;
      end else if (isPagePort) begin
        stb.rdKind = RD_PAGE;
      end else if (portIdx == P_STATCMD) begin
        stb.rdKind   = RD_STATUS;
        stb.rdStatus = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bytePtr <= 1'b0;
    end else if (wrEn && (portIdx == P_PTRCLR || portIdx == P_MCLR)) begin
      bytePtr <= 1'b0;
    end else if ((wrEn || rdEn) && isChanPort) begin
      bytePtr <= ~bytePtr;
    end
  end

endmodule

// File: rtl/dma_regfile_data.sv
module dma_regfile_data
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [NUM_CH-1:0]              tcSet,
  input  logic [NUM_CH-1:0]              hwReq,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_CH-1:0]              maskOut,
  output logic [DATA_W-1:0]              cmdOut,
  output logic [2*NUM_CH-1:0]            statusOut,
  output logic [NUM_CH*(DATA_W-2)-1:0]   modeFlat,
  output logic [NUM_CH*DATA_W-1:0]       pageFlat,
  output logic [NUM_CH*2*DATA_W-1:0]     baseAddrFlat,
  output logic [NUM_CH*2*DATA_W-1:0]     curAddrFlat,
  output logic [NUM_CH*2*DATA_W-1:0]     baseCntFlat,
  output logic [NUM_CH*2*DATA_W-1:0]     curCntFlat
);

  localparam int WORD_W = 2 * DATA_W;
  localparam int MODE_W = DATA_W - 2;
  localparam int CH_W   = $clog2(NUM_CH);

  logic [NUM_CH-1:0] mask;
  logic [NUM_CH-1:0] swReq;
  logic [NUM_CH-1:0] tcFlag;
  logic [DATA_W-1:0] cmdReg;
  logic [CH_W-1:0]   selCh;
  logic [CH_W-1:0]   dataCh;

  assign selCh  = stb.chan[CH_W-1:0];
  assign dataCh = wrData[CH_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [WORD_W-1:0] bAddr, cAddr, bCnt, cCnt;
    logic [DATA_W-1:0] page;
    logic [MODE_W-1:0] mode;
    logic              hit;

    assign hit = (selCh == CH_W'(c));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bAddr <= '0;
        cAddr <= '0;
        bCnt  <= '0;
        cCnt  <= '0;
        page  <= '0;
        mode  <= '0;
      end else begin
        if (hit && stb.wrAddr) begin
          if (stb.hiByte) begin
            bAddr[WORD_W-1:DATA_W] <= wrData;
            cAddr[WORD_W-1:DATA_W] <= wrData;
          end else begin
            bAddr[DATA_W-1:0] <= wrData;
            cAddr[DATA_W-1:0] <= wrData;
          end
        end
        if (hit && stb.wrCnt) begin
          if (stb.hiByte) begin
            bCnt[WORD_W-1:DATA_W] <= wrData;
            cCnt[WORD_W-1:DATA_W] <= wrData;
          end else begin
            bCnt[DATA_W-1:0] <= wrData;
            cCnt[DATA_W-1:0] <= wrData;
          end
        end
        if (hit && stb.wrPage) page <= wrData;
        if (stb.wrMode && dataCh == CH_W'(c)) mode <= wrData[DATA_W-1:2];
      end
    end

    assign baseAddrFlat[c*WORD_W +: WORD_W] = bAddr;
    assign curAddrFlat[c*WORD_W +: WORD_W]  = cAddr;
    assign baseCntFlat[c*WORD_W +: WORD_W]  = bCnt;
    assign curCntFlat[c*WORD_W +: WORD_W]   = cCnt;
    assign pageFlat[c*DATA_W +: DATA_W]     = page;
    assign modeFlat[c*MODE_W +: MODE_W]     = mode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask <= '1;
    end else if (stb.masterClr) begin
      mask <= '1;
    end else if (stb.clrMasks) begin
      mask <= '0;
    end else if (stb.wrAllMasks) begin
      mask <= wrData[NUM_CH-1:0];
    end else if (stb.wrOneMask) begin
      mask[dataCh] <= wrData[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swReq <= '0;
    end else if (stb.masterClr) begin
      swReq <= '0;
    end else if (stb.wrReq) begin
      swReq[dataCh] <= wrData[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcFlag <= '0;
    end else if (stb.masterClr || stb.rdStatus) begin
      tcFlag <= tcSet;
    end else begin
      tcFlag <= tcFlag | tcSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (stb.masterClr) begin
      cmdReg <= '0;
    end else if (stb.wrCmd) begin
      cmdReg <= wrData;
    end
  end

  assign maskOut   = mask;
  assign cmdOut    = cmdReg;
  assign statusOut = {swReq | hwReq, tcFlag};

  logic [WORD_W-1:0] selWord;

  always_comb begin
    selWord = '0;
    rdData  = '0;
    case (stb.rdKind)
      RD_ADDR:   selWord = curAddrFlat[selCh*WORD_W +: WORD_W];
      RD_CNT:    selWord = curCntFlat[selCh*WORD_W +: WORD_W];
      default:   selWord = '0;
    endcase
    case (stb.rdKind)
      RD_ADDR, RD_CNT:
        rdData = stb.hiByte ? selWord[WORD_W-1:DATA_W] : selWord[DATA_W-1:0];
      RD_STATUS: rdData = statusOut;
      RD_PAGE:   rdData = pageFlat[selCh*DATA_W +: DATA_W];
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [PORT_W-1:0]            portIdx,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  input  logic [NUM_CH-1:0]            tcSet,
  input  logic [NUM_CH-1:0]            hwReq,
  output logic [NUM_CH-1:0]            maskOut,
  output logic [DATA_W-1:0]            cmdOut,
  output logic [2*NUM_CH-1:0]          statusOut,
  output logic [NUM_CH*(DATA_W-2)-1:0] modeFlat,
  output logic [NUM_CH*DATA_W-1:0]     pageFlat,
  output logic [NUM_CH*2*DATA_W-1:0]   baseAddrFlat,
  output logic [NUM_CH*2*DATA_W-1:0]   curAddrFlat,
  output logic [NUM_CH*2*DATA_W-1:0]   baseCntFlat,
  output logic [NUM_CH*2*DATA_W-1:0]   curCntFlat
);

  strobe_t stb;

  dma_regfile_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .portIdx (portIdx),
    .stb     (stb)
  );

  dma_regfile_data #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .tcSet        (tcSet),
    .hwReq        (hwReq),
    .rdData       (rdData),
    .maskOut      (maskOut),
    .cmdOut       (cmdOut),
    .statusOut    (statusOut),
    .modeFlat     (modeFlat),
    .pageFlat     (pageFlat),
    .baseAddrFlat (baseAddrFlat),
    .curAddrFlat  (curAddrFlat),
    .baseCntFlat  (baseCntFlat),
    .curCntFlat   (curCntFlat)
  );

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         wrEn,
  input logic                         rdEn,
  input logic [PORT_W-1:0]            portIdx,
  input logic [DATA_W-1:0]            wrData,
  input logic [DATA_W-1:0]            rdData,
  input logic [NUM_CH-1:0]            tcSet,
  input logic [NUM_CH-1:0]            hwReq,
  input logic [NUM_CH-1:0]            maskOut,
  input logic [DATA_W-1:0]            cmdOut,
  input logic [2*NUM_CH-1:0]          statusOut,
  input logic [NUM_CH*(DATA_W-2)-1:0] modeFlat,
  input logic [NUM_CH*DATA_W-1:0]     pageFlat,
  input logic [NUM_CH*2*DATA_W-1:0]   baseAddrFlat,
  input logic [NUM_CH*2*DATA_W-1:0]   curAddrFlat,
  input logic [NUM_CH*2*DATA_W-1:0]   baseCntFlat,
  input logic [NUM_CH*2*DATA_W-1:0]   curCntFlat
);

  localparam int WORD_W = 2 * DATA_W;

  assert_addr_copies_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portIdx[4:3] == 2'b00 && !portIdx[0]) |=>
      baseAddrFlat[$past(portIdx[2:1])*WORD_W +: WORD_W] ==
      curAddrFlat[$past(portIdx[2:1])*WORD_W +: WORD_W]);

  assert_tc_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && portIdx == P_STATCMD && tcSet == '0) |=>
      statusOut[NUM_CH-1:0] == '0);

  assert_tc_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|tcSet) |=> ((statusOut[NUM_CH-1:0] & $past(tcSet)) == $past(tcSet)));

  assert_one_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portIdx == P_ONEMASK) |=>
      maskOut[$past(wrData[1:0])] == $past(wrData[2]));

  assert_master_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portIdx == P_MCLR) |=> (maskOut == '1 && cmdOut == '0));

  assert_unmask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portIdx == P_UNMASK) |=> maskOut == '0);

  assert_all_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portIdx == P_ALLMASK) |=> maskOut == $past(wrData[NUM_CH-1:0]));

endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dma_regfile_tb_top.sv
module dma_regfile_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  portIdx = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  tcSet = '0;
  logic [3:0]  hwReq = '0;
  logic [3:0]  maskOut;
  logic [7:0]  cmdOut;
  logic [7:0]  statusOut;
  logic [23:0] modeFlat;
  logic [31:0] pageFlat;
  logic [63:0] baseAddrFlat, curAddrFlat, baseCntFlat, curCntFlat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regfile dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portIdx(portIdx),
    .wrData(wrData), .rdData(rdData), .tcSet(tcSet), .hwReq(hwReq),
    .maskOut(maskOut), .cmdOut(cmdOut), .statusOut(statusOut),
    .modeFlat(modeFlat), .pageFlat(pageFlat), .baseAddrFlat(baseAddrFlat),
    .curAddrFlat(curAddrFlat), .baseCntFlat(baseCntFlat), .curCntFlat(curCntFlat)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrPort(input logic [4:0] idx, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; portIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdPort(input logic [4:0] idx, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; portIdx = idx;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseTc(input logic [3:0] v);
    @(negedge clk);
    tcSet = v;
    @(negedge clk);
    tcSet = '0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 mask", maskOut, 4'hF);
    check("R1 status", statusOut, 8'h00);
    check("R1 cmd", cmdOut, 8'h00);
    check("R1 mode", modeFlat, 24'h0);
    check("R1 addr", baseAddrFlat | curAddrFlat | baseCntFlat | curCntFlat, 64'h0);
    rdPort(5'd16, d); check("R1 page read", d, 8'h00);
  endtask

  task automatic testAddrCount();
    logic [7:0] d;
    wrPort(5'd2, 8'h34); wrPort(5'd2, 8'h12);
    check("R2 base addr ch1", baseAddrFlat[31:16], 16'h1234);
    check("R2 cur addr ch1", curAddrFlat[31:16], 16'h1234);
    rdPort(5'd2, d); check("R3 addr low", d, 8'h34);
    rdPort(5'd2, d); check("R3 addr high", d, 8'h12);
    wrPort(5'd7, 8'hCD); wrPort(5'd7, 8'hAB);
    check("R2 base cnt ch3", baseCntFlat[63:48], 16'hABCD);
    check("R2 cur cnt ch3", curCntFlat[63:48], 16'hABCD);
    rdPort(5'd7, d); check("R3 cnt low", d, 8'hCD);
    rdPort(5'd7, d); check("R3 cnt high", d, 8'hAB);
  endtask

  task automatic testPtrClear();
    wrPort(5'd0, 8'h11);
    wrPort(5'd12, 8'h5A);
    wrPort(5'd0, 8'h22);
    check("R10 low lane after clear", curAddrFlat[15:0], 16'h0022);
    wrPort(5'd12, 8'h00);
  endtask

  task automatic testStatus();
    logic [7:0] d;
    hwReq = 4'h2;
    pulseTc(4'h5);
    rdPort(5'd8, d); check("R4 status read", d, 8'h25);
    rdPort(5'd8, d); check("R4 tc cleared", d, 8'h20);
    wrPort(5'd9, 8'h07); check("R9 sw req set", statusOut, 8'hA0);
    wrPort(5'd9, 8'h03); check("R9 sw req clr", statusOut, 8'h20);
    hwReq = 4'h0;
  endtask

  task automatic testMasks();
    wrPort(5'd10, 8'h02); check("R5 unmask ch2", maskOut, 4'hB);
    wrPort(5'd10, 8'h06); check("R5 mask ch2", maskOut, 4'hF);
    wrPort(5'd14, 8'hFF); check("R8 unmask all", maskOut, 4'h0);
    wrPort(5'd15, 8'hFA); check("R8 load all", maskOut, 4'hA);
  endtask

  task automatic testModePageCmd();
    logic [7:0] d;
    wrPort(5'd11, 8'hB5);
    check("R6 mode ch1", modeFlat[11:6], 6'h2D);
    check("R6 mode ch0 untouched", modeFlat[5:0], 6'h00);
    wrPort(5'd17, 8'h9C);
    check("R11 page ch1", pageFlat[15:8], 8'h9C);
    rdPort(5'd17, d); check("R11 page read", d, 8'h9C);
    wrPort(5'd8, 8'h04); check("R12 cmd", cmdOut, 8'h04);
    rdPort(5'd20, d); check("R12 unimpl read", d, 8'h00);
    rdPort(5'd13, d); check("R12 port13 read", d, 8'h00);
  endtask

  task automatic testMasterClear();
    wrPort(5'd9, 8'h05);
    wrPort(5'd4, 8'h77);
    pulseTc(4'h1);
    wrPort(5'd13, 8'h3C);
    check("R7 masks", maskOut, 4'hF);
    check("R7 cmd", cmdOut, 8'h00);
    check("R7 status", statusOut, 8'h00);
    wrPort(5'd4, 8'h55);
    check("R7 pointer low lane", curAddrFlat[47:32], 16'h0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddrCount();
    testPtrClear();
    testStatus();
    testMasks();
    testModePageCmd();
    testMasterClear();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule